// File: doc/BRIEF.md
# Serial Program Image Loader

This block fills a word-addressed instruction memory from a byte stream that arrives on one asynchronous serial line. The line carries 8-bit frames. The block checks the framing of each frame and packs every four good bytes into one 32-bit word, with the first byte in the high-order position. It presents each word on a simple write port: an address, 32 bits of data and a strobe that lasts one cycle. The words go to consecutive addresses starting at zero.

The sender must keep the line idle until `ready` is high. The image ends with the reserved word 0x00000FFF. That word is never written: it raises `done`, and the block then ignores the line. A frame whose stop bit is low is dropped and raises a sticky framing flag. A word that arrives after the whole address space has been written, and that is not the terminator, raises a sticky overflow flag and stops all loading.

Top module: `img_serial_loader`

## Requirements
- R1: A frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit. The line idles high. Each bit is sampled near the middle of its bit time, and a bit time is `CLKS_PER_BIT` clocks.
- R2: The receiver finds each frame again from its own start edge. A byte whose start bit is one eighth of a bit time longer than normal is still decoded correctly.
- R3: Four accepted bytes form one word. The first byte goes to bits 31:24, the second to 23:16, the third to 15:8 and the fourth to 7:0.
- R4: Each non-terminator word produces a `mem_we` pulse of exactly one cycle. The first write of an image goes to address 0, and each later write goes to the address one above the previous write.
- R5: The word 0x00000FFF is never written. When it arrives, `done` goes high and stays high, and later bytes cause no write.
- R6: If the stop bit is low, `frame_err` goes high and stays high, and the byte is dropped. A dropped byte does not count toward the four bytes of a word.
- R7: Once 2^`ADDR_W` words have been written, a further non-terminator word sets the sticky `overflow` flag and is not written, and all later bytes are ignored. A terminator arriving at that point sets `done` instead.
- R8: `ready` is low while `rst` is high. It is high from the first clock edge after reset is released until `done` or `overflow` goes high.
- R9: The synchronous reset `rst` clears `done`, `frame_err` and `overflow`, returns the receiver to idle and clears the byte count, so the next image starts again at address 0.
- R10: A low pulse on the line that is shorter than half a bit time does not start a frame and does not add a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| ready | output | 1 | High when the loader accepts an image |
| mem_we | output | 1 | One-cycle write strobe |
| mem_addr | output | ADDR_W (12) | Word address of the write |
| mem_data | output | 32 | Word to be written |
| done | output | 1 | Terminator word received (sticky) |
| frame_err | output | 1 | A stop bit was low (sticky) |
| overflow | output | 1 | Image larger than the memory (sticky) |

## Verification
The assertions assume three things about the stimulus:
- frames are spaced so that a new word can never finish within one cycle of the previous write;
- `rx_line` stays high, apart from deliberate short pulses, while no frame is being sent;
- `rst` is raised only while the line is idle.

The bench meets these assumptions by driving every bit for a whole number of bit times on the falling clock edge. It leaves at least one idle bit time after every stop bit, including a low stop bit. It applies reset only between scenarios.

// File: rtl/img_loader_pkg.sv
package img_loader_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
  localparam int ACC_W   = WORD_W - BYTE_W;
  localparam logic [WORD_W-1:0] END_WORD = 32'h0000_0FFF;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  // serial data arrives LSB first: new bit enters at the top
  function automatic logic [BYTE_W-1:0] shift_in_lsb_first(input logic [BYTE_W-1:0] sh,
                                                            input logic b);
    return {b, sh[BYTE_W-1:1]};
  endfunction

  // earlier bytes sit above the newest one
  function automatic word_t pack_word(input logic [ACC_W-1:0] acc,
                                      input logic [BYTE_W-1:0] b);
    return {acc, b};
  endfunction

  function automatic logic is_end_word(input word_t w);
    return w == END_WORD;
  endfunction
endpackage

// File: rtl/ldr_sync2.sv
module ldr_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta   <= 1'b1;
      d_sync <= 1'b1;
    end else begin
      meta   <= d_async;
      d_sync <= meta;
    end
  end
endmodule

// File: rtl/ldr_uart_rx.sv
module ldr_uart_rx import img_loader_pkg::*; #(
  parameter int CLKS_PER_BIT = 87
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_s,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val,
  output logic              ferr_stb
);
  localparam int CW   = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [CW-1:0] FULL_END = CW'(CLKS_PER_BIT - 1);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [2:0]        bit_idx;
  logic [BYTE_W-1:0] sh;

  assign byte_val = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      sh       <= '0;
      byte_stb <= 1'b0;
      ferr_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      ferr_stb <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!rx_s) st <= RX_START;
        end
        RX_START: begin
          if (cnt == HALF_END) begin
            cnt     <= '0;
            bit_idx <= '0;
            st      <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == FULL_END) begin
            cnt <= '0;
            sh  <= shift_in_lsb_first(sh, rx_s);
            if (bit_idx == 3'd7) st <= RX_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == FULL_END) begin
            cnt <= '0;
            st  <= RX_IDLE;
            if (rx_s) byte_stb <= 1'b1;
            else      ferr_stb <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldr_word_pack.sv
module ldr_word_pack import img_loader_pkg::*; #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output word_t             mem_data,
  output logic              done,
  output logic              overflow
);
  localparam int BC_W = $clog2(BYTES_PER_WORD);
  localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(BYTES_PER_WORD - 1);

  logic [BC_W-1:0]   bcnt;
  logic [ACC_W-1:0]  acc;
  logic [ADDR_W-1:0] waddr;
  logic              full;

  wire   accept    = byte_stb && !done && !overflow;
  wire   last_byte = (bcnt == LAST_BYTE);
  word_t word_now;
  assign word_now  = pack_word(acc, byte_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt     <= '0;
      acc      <= '0;
      waddr    <= '0;
      full     <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (accept) begin
        if (!last_byte) begin
          acc  <= {acc[ACC_W-BYTE_W-1:0], byte_val};
          bcnt <= bcnt + 1'b1;
        end else begin
          bcnt <= '0;
          if (is_end_word(word_now)) begin
            done <= 1'b1;
          end else if (full) begin
            overflow <= 1'b1;
          end else begin
            mem_we   <= 1'b1;
            mem_addr <= waddr;
            mem_data <= word_now;
            waddr    <= waddr + 1'b1;
            if (waddr == '1) full <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/img_serial_loader.sv
module img_serial_loader import img_loader_pkg::*; #(
  parameter int CLKS_PER_BIT = 87,
  parameter int ADDR_W       = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  output logic              ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              done,
  output logic              frame_err,
  output logic              overflow
);
  logic              rx_s;
  logic              byte_stb;
  logic              ferr_stb;
  logic [BYTE_W-1:0] byte_val;
  logic              up_q;

  ldr_sync2 u_sync (
    .clk(clk), .rst(rst), .d_async(rx_line), .d_sync(rx_s)
  );

  ldr_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst(rst), .rx_s(rx_s),
    .byte_stb(byte_stb), .byte_val(byte_val), .ferr_stb(ferr_stb)
  );

  ldr_word_pack #(.ADDR_W(ADDR_W)) u_pack (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_val(byte_val),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .done(done), .overflow(overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q      <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      up_q <= 1'b1;
      if (ferr_stb) frame_err <= 1'b1;
    end
  end

  assign ready = up_q && !done && !overflow;
endmodule

// File: rtl/img_loader_checker.sv
module img_loader_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic              done,
  input logic              frame_err,
  input logic              overflow,
  input logic              byte_stb,
  input logic              ferr_stb
);
  logic [ADDR_W-1:0] wcnt;
  always_ff @(posedge clk) begin
    if (rst) wcnt <= '0;
    else if (mem_we) wcnt <= wcnt + 1'b1;
  end

  assert_frame_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(byte_stb && ferr_stb));
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  assert_addr_seq_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == wcnt);
  assert_no_end_write_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_data != 32'h0000_0FFF);
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  assert_no_we_done_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);
  assert_ferr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);
  assert_ferr_set_R6: assert property (@(posedge clk) disable iff (rst)
    ferr_stb |=> frame_err);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_ovf_no_we_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !mem_we);
  assert_ready_gate_R8: assert property (@(posedge clk) disable iff (rst)
    ready |-> !done && !overflow);
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !done && !frame_err && !overflow && !ready && !mem_we);
endmodule

bind img_serial_loader img_loader_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_data(mem_data), .done(done), .frame_err(frame_err), .overflow(overflow),
  .byte_stb(byte_stb), .ferr_stb(ferr_stb)
);

// File: tb/tb_img_serial_loader.sv
`timescale 1ns/1ps
module tb_img_serial_loader;
  localparam int CPB = 16;
  localparam int AW  = 3;
  localparam int NW  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1;
  logic ready, mem_we, done, frame_err, overflow;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_data;

  int checks = 0;
  int errors = 0;
  int n_we = 0;
  int pulse_bad = 0;
  logic prev_we = 1'b0;
  logic [AW-1:0] log_a [0:63];
  logic [31:0]   log_d [0:63];

  always #2 clk = ~clk;

  img_serial_loader #(.CLKS_PER_BIT(CPB), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .ready(ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data), .done(done),
    .frame_err(frame_err), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      log_a[n_we & 63] = mem_addr;
      log_d[n_we & 63] = mem_data;
      n_we = n_we + 1;
      if (prev_we) pulse_bad = pulse_bad + 1;
    end
    prev_we = mem_we;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit good_stop = 1'b1,
                           input int stretch = 0);
    rx_line = 1'b0; idle(CPB + stretch);
    for (int i = 0; i < 8; i++) begin rx_line = b[i]; idle(CPB); end
    rx_line = good_stop; idle(CPB);
    rx_line = 1'b1; idle(CPB);
  endtask

  task automatic send_word(input logic [31:0] w, input int stretch = 0);
    for (int k = 3; k >= 0; k--) send_byte(w[8*k +: 8], 1'b1, stretch);
  endtask

  task automatic do_reset();
    rst = 1'b1; idle(3);
    check(ready == 1'b0, "R8 ready low in reset", 32'(ready), 0);
    rst = 1'b0; idle(2);
  endtask

  task automatic t_reset_state();
    check(ready == 1'b1, "R8 ready after reset", 32'(ready), 1);
    check({done, frame_err, overflow} == 3'b000, "R9 flags clear",
          32'({done, frame_err, overflow}), 0);
  endtask

  task automatic t_basic();
    int b = n_we;
    send_word(32'h1234_5678);
    send_word(32'hA501_80FF);
    check(n_we == b + 2, "R4 two writes", 32'(n_we - b), 2);
    check(log_d[b] == 32'h1234_5678, "R3 byte order", log_d[b], 32'h1234_5678);
    check(log_d[b+1] == 32'hA501_80FF, "R1 lsb-first bits", log_d[b+1], 32'hA501_80FF);
    check(log_a[b] == 0 && log_a[b+1] == 1, "R4 addresses 0,1",
          32'({log_a[b], log_a[b+1]}), 32'h01);
  endtask

  task automatic t_stretch();
    int b = n_we;
    send_word(32'hDEAD_BEEF, CPB / 8);
    check(n_we == b + 1 && log_d[b] == 32'hDEAD_BEEF, "R2 stretched start",
          log_d[b], 32'hDEAD_BEEF);
    check(log_a[b] == 2, "R4 address 2", 32'(log_a[b]), 2);
  endtask

  task automatic t_glitch();
    int b = n_we;
    rx_line = 1'b0; idle(CPB / 4); rx_line = 1'b1; idle(2 * CPB);
    check(n_we == b, "R10 glitch no write", 32'(n_we - b), 0);
    send_word(32'h1122_3344);
    check(log_d[b] == 32'h1122_3344, "R10 glitch not a byte", log_d[b], 32'h1122_3344);
  endtask

  task automatic t_frame();
    int b = n_we;
    send_byte(8'h99, 1'b0);
    check(frame_err == 1'b1, "R6 frame_err set", 32'(frame_err), 1);
    send_word(32'h5566_7788);
    check(log_d[b] == 32'h5566_7788, "R6 byte dropped", log_d[b], 32'h5566_7788);
    check(frame_err == 1'b1, "R6 frame_err sticky", 32'(frame_err), 1);
  endtask

  task automatic t_term();
    int b = n_we;
    send_word(32'h0000_0FFF);
    check(done == 1'b1, "R5 done set", 32'(done), 1);
    check(n_we == b, "R5 terminator not written", 32'(n_we - b), 0);
    check(ready == 1'b0, "R8 ready drops on done", 32'(ready), 0);
    send_word(32'hCAFE_F00D);
    check(n_we == b && done, "R5 bytes ignored after done", 32'(n_we - b), 0);
  endtask

  task automatic t_overflow();
    int b = n_we;
    for (int i = 0; i < NW; i++) send_word(32'h100 + 32'(i));
    check(n_we == b + NW && log_a[b+NW-1] == AW'(NW-1), "R4 fills address space",
          32'(n_we - b), NW);
    check(overflow == 1'b0, "R7 no overflow when exactly full", 32'(overflow), 0);
    send_word(32'h7777_7777);
    check(overflow == 1'b1 && n_we == b + NW, "R7 overflow set, no write",
          32'(overflow), 1);
    check(ready == 1'b0, "R8 ready drops on overflow", 32'(ready), 0);
    send_word(32'h0000_0FFF);
    check(done == 1'b0, "R7 later bytes ignored", 32'(done), 0);
  endtask

  task automatic t_full_term();
    int b = n_we;
    for (int i = 0; i < NW; i++) send_word(32'h200 + 32'(i));
    send_word(32'h0000_0FFF);
    check(done == 1'b1 && overflow == 1'b0, "R7 terminator after full",
          32'({done, overflow}), 32'b10);
    check(n_we == b + NW, "R7 write count when full", 32'(n_we - b), NW);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_basic();
    t_stretch();
    t_glitch();
    t_frame();
    t_term();
    do_reset();
    t_reset_state();
    begin
      int b = n_we;
      send_word(32'h0BAD_CAFE);
      check(log_a[b] == 0, "R9 address restarts", 32'(log_a[b]), 0);
    end
    do_reset();
    t_overflow();
    do_reset();
    t_full_term();
    check(pulse_bad == 0, "R4 single-cycle strobe", 32'(pulse_bad), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule